// File: doc/BRIEF.md
# Configurable UART Serial Engine

This block moves characters between a parallel byte interface and a pair of asynchronous serial lines. All of its timing comes from one system clock. A programmable count of system clocks sets the length of every bit on the line. A second programmable count sets where inside each received bit the line is sampled. That sample point is independent of the bit length, and any setting below 7 clocks behaves as 7. Characters carry 5 to 8 data bits. A parity bit is optional and its polarity is selectable. The transmitter ends each character with one or two stop bits.

The transmitter accepts a byte through a valid/ready handshake and drives the frame on its output line. The receiver passes the input line through a synchronizer. It waits for a low level and confirms the start bit at the sample point, dropping back to idle if the low was only a glitch. It then samples each following bit at the same offset. At the first stop bit it presents the byte together with parity and framing flags for one clock. A global enable gates both directions, and each direction also has its own enable.

The configuration is expected to be stable while a character is in flight. The bit count must be at least 10, and the effective sample offset must not exceed the bit count minus 2.

Top module: `serialEngine`

## Requirements
- R1: After reset, with all enables high, `txLine` is 1, `txReady` is 1 and `rxValid` is 0. `txLine` is 1 whenever `txReady` is 1.
- R2: When `txValid` and `txReady` are both high at a clock edge, `txReady` falls and a frame begins on that edge. The frame is a start bit at 0 followed by the data bits, least significant first. Every bit lasts exactly `bitCount` clocks.
- R3: `charLen` selects the number of data bits as 5 + `charLen` (0 selects 5, 1 selects 6, 2 selects 7, 3 selects 8). Only those low bits of `txData` are sent. The received `rxData` has all bits above the character length at 0.
- R4: With `parityEn` = 1, one parity bit follows the data. With `paritySel` = 1 it is the XOR of the data bits (even parity). With `paritySel` = 0 it is the inverted XOR (odd parity). With `parityEn` = 0 no parity bit is sent.
- R5: The frame closes with one stop bit at 1, or two when `twoStop` = 1. `txReady` is 0 throughout the frame and returns to 1 on the clock after the last stop bit ends.
- R6: A frame in the same format on `rxLine` produces exactly one `rxValid` pulse, one clock long, carrying the decoded byte.
- R7: `rxParityErr` is 1 with `rxValid` when the received parity bit differs from the one computed under R4. It is always 0 when `parityEn` = 0.
- R8: `rxFrameErr` is 1 with `rxValid` when the first stop bit is sampled at 0. A low stop bit followed by an idle line produces no further character.
- R9: A `sampleOffset` below 7 acts as 7. With offset 2, a low pulse of 6 clocks on `rxLine` is rejected, and a valid frame still decodes.
- R10: If the line is high again at the start-bit sample point, the receiver returns to idle and reports nothing. With offset 8, a low pulse of 8 clocks produces no `rxValid`.
- R11: With `uartEn` or `txEn` at 0, `txReady` is 0, `txLine` stays 1 and `txValid` is ignored. With `uartEn` or `rxEn` at 0, frames on `rxLine` produce no `rxValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| uartEn | input | 1 | Global enable for both directions |
| txEn | input | 1 | Transmitter enable |
| rxEn | input | 1 | Receiver enable |
| bitCount | input | 24 | System clocks per serial bit |
| sampleOffset | input | 24 | Clock offset of the sample point inside a received bit (floor 7) |
| charLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Adds and checks a parity bit |
| paritySel | input | 1 | 1 = even parity, 0 = odd parity |
| twoStop | input | 1 | 1 = two transmitted stop bits |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Byte offered for sending |
| txReady | output | 1 | Transmitter idle and enabled |
| txLine | output | 1 | Serial output, idles high |
| rxLine | input | 1 | Serial input, asynchronous |
| rxData | output | 8 | Last received byte, zero-extended |
| rxValid | output | 1 | One-clock pulse when a character completes |
| rxParityErr | output | 1 | Parity mismatch on the last character |
| rxFrameErr | output | 1 | First stop bit was low on the last character |

## Verification
Most bad internal states in this engine show up on the lines within one bit period. A bit counter that wraps at the wrong value moves every later edge of `txLine`, and the mid-bit sampling catches it on the next bit. A wrong bit index or shift value corrupts a data bit or the parity bit in the same frame. On the receive side, a sample point that is off or a start check that is missing shows up as a wrong byte, an error flag set when it should be clear, or an `rxValid` pulse that is extra or absent. The bench counts these pulses and checks them a few bit periods after each stimulus, using the same line for transmit and receive. That gives every combination of length, parity and stop setting a check in both directions.

// File: rtl/serialPkg.sv
package serialPkg;
  localparam int MAX_BITS = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } serPhase_e;

  typedef struct packed {
    serPhase_e  txPhase;
    logic       txLoad;
    logic       txShift;
    logic       rxClear;
    logic       rxCapture;
    logic       rxParCapture;
    logic       rxDone;
    logic [2:0] rxBitNo;
  } serStrobe_t;

  function automatic logic [MAX_BITS-1:0] charMask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic [2:0] lastBitIdx(input logic [1:0] len);
    return 3'(len) + 3'd4;
  endfunction
endpackage

// File: rtl/serialCtrl.sv
module serialCtrl
  import serialPkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int MIN_SAMPLE = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uartEn,
  input  logic             txEn,
  input  logic             rxEn,
  input  logic [CNT_W-1:0] bitCount,
  input  logic [CNT_W-1:0] sampleOffset,
  input  logic [1:0]       charLen,
  input  logic             parityEn,
  input  logic             twoStop,
  input  logic             txValid,
  input  logic             rxBit,
  output logic             txReady,
  output serStrobe_t       strobe
);
  localparam logic [CNT_W-1:0] MIN_OFF = CNT_W'(MIN_SAMPLE);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  serPhase_e        txPh, rxPh;
  logic [CNT_W-1:0] txCnt, rxCnt, effOff;
  logic [2:0]       txBitNo, rxBitNo, lastIdx;
  logic             txStopNo;
  logic             txActive, rxActive, txWrap, rxWrap, rxSampleNow, txLoad;

  assign txActive    = uartEn & txEn;
  assign rxActive    = uartEn & rxEn;
  assign lastIdx     = lastBitIdx(charLen);
  assign effOff      = (sampleOffset < MIN_OFF) ? MIN_OFF : sampleOffset;
  assign txWrap      = (txCnt == bitCount - ONE);
  assign rxWrap      = (rxCnt == bitCount - ONE);
  assign rxSampleNow = (rxPh != PH_IDLE) && (rxCnt == effOff);
  assign txReady     = txActive && (txPh == PH_IDLE);
  assign txLoad      = txValid && txReady;

  // transmit sequencer
  always_ff @(posedge clk) begin
    if (!rstN || !txActive) begin
      txPh     <= PH_IDLE;
      txCnt    <= '0;
      txBitNo  <= '0;
      txStopNo <= 1'b0;
    end else if (txLoad) begin
      txPh     <= PH_START;
      txCnt    <= '0;
      txBitNo  <= '0;
      txStopNo <= 1'b0;
    end else if (txPh != PH_IDLE) begin
      if (!txWrap) begin
        txCnt <= txCnt + ONE;
      end else begin
        txCnt <= '0;
        case (txPh)
          PH_START: txPh <= PH_DATA;
          PH_DATA: begin
            if (txBitNo == lastIdx) txPh <= parityEn ? PH_PAR : PH_STOP;
            else                    txBitNo <= txBitNo + 3'd1;
          end
          PH_PAR: txPh <= PH_STOP;
          PH_STOP: begin
            if (twoStop && !txStopNo) txStopNo <= 1'b1;
            else                      txPh <= PH_IDLE;
          end
          default: txPh <= PH_IDLE;
        endcase
      end
    end
  end

  // receive sequencer
  always_ff @(posedge clk) begin
    if (!rstN || !rxActive) begin
      rxPh    <= PH_IDLE;
      rxCnt   <= '0;
      rxBitNo <= '0;
    end else if (rxPh == PH_IDLE) begin
      rxCnt   <= '0;
      rxBitNo <= '0;
      if (!rxBit) rxPh <= PH_START;
    end else begin
      rxCnt <= rxWrap ? '0 : rxCnt + ONE;
      if (rxSampleNow && (rxPh == PH_START) && rxBit) begin
        rxPh <= PH_IDLE;
      end else if (rxSampleNow && (rxPh == PH_STOP)) begin
        rxPh <= PH_IDLE;
      end else if (rxWrap) begin
        case (rxPh)
          PH_START: rxPh <= PH_DATA;
          PH_DATA: begin
            if (rxBitNo == lastIdx) rxPh <= parityEn ? PH_PAR : PH_STOP;
            else                    rxBitNo <= rxBitNo + 3'd1;
          end
          PH_PAR:  rxPh <= PH_STOP;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe              = '0;
    strobe.txPhase      = txPh;
    strobe.txLoad       = txLoad;
    strobe.txShift      = (txPh == PH_DATA) && txWrap && (txBitNo != lastIdx);
    strobe.rxClear      = rxActive && (rxPh == PH_IDLE) && !rxBit;
    strobe.rxCapture    = rxActive && rxSampleNow && (rxPh == PH_DATA);
    strobe.rxParCapture = rxActive && rxSampleNow && (rxPh == PH_PAR);
    strobe.rxDone       = rxActive && rxSampleNow && (rxPh == PH_STOP);
    strobe.rxBitNo      = rxBitNo;
  end
endmodule

// File: rtl/serialDatapath.sv
module serialDatapath
  import serialPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  logic [1:0]          charLen,
  input  logic                parityEn,
  input  logic                paritySel,
  input  logic [MAX_BITS-1:0] txData,
  input  serStrobe_t          strobe,
  output logic                txLine,
  output logic                rxBit,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxValid,
  output logic                rxParityErr,
  output logic                rxFrameErr
);
  logic [MAX_BITS-1:0]    mask, txMasked, txSh, rxSh;
  logic                   txPar, rxParQ, rxParExp;
  logic [SYNC_STAGES-1:0] syncQ;

  assign mask     = charMask(charLen);
  assign txMasked = txData & mask;
  assign rxParExp = paritySel ? ^rxSh : ~^rxSh;
  assign rxBit    = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh  <= '0;
      txPar <= 1'b0;
    end else if (strobe.txLoad) begin
      txSh  <= txMasked;
      txPar <= paritySel ? ^txMasked : ~^txMasked;
    end else if (strobe.txShift) begin
      txSh  <= txSh >> 1;
    end
  end

  always_comb begin
    case (strobe.txPhase)
      PH_START: txLine = 1'b0;
      PH_DATA:  txLine = txSh[0];
      PH_PAR:   txLine = txPar;
      default:  txLine = 1'b1;
    endcase
  end

  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rxLine;
      end
    end else begin : gSyncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh   <= '0;
      rxParQ <= 1'b0;
    end else begin
      if (strobe.rxClear)      rxSh <= '0;
      else if (strobe.rxCapture) rxSh[strobe.rxBitNo] <= rxBit;
      if (strobe.rxParCapture) rxParQ <= rxBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid     <= 1'b0;
      rxData      <= '0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
    end else begin
      rxValid <= strobe.rxDone;
      if (strobe.rxDone) begin
        rxData      <= rxSh;
        rxFrameErr  <= !rxBit;
        rxParityErr <= parityEn && (rxParQ != rxParExp);
      end
    end
  end
endmodule

// File: rtl/serialEngine.sv
module serialEngine
  import serialPkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int MIN_SAMPLE  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uartEn,
  input  logic             txEn,
  input  logic             rxEn,
  input  logic [CNT_W-1:0] bitCount,
  input  logic [CNT_W-1:0] sampleOffset,
  input  logic [1:0]       charLen,
  input  logic             parityEn,
  input  logic             paritySel,
  input  logic             twoStop,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic             txLine,
  input  logic             rxLine,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             rxParityErr,
  output logic             rxFrameErr
);
  serStrobe_t strobe;
  logic       rxBit;

  serialCtrl #(.CNT_W(CNT_W), .MIN_SAMPLE(MIN_SAMPLE)) uCtrl (
    .clk(clk), .rstN(rstN), .uartEn(uartEn), .txEn(txEn), .rxEn(rxEn),
    .bitCount(bitCount), .sampleOffset(sampleOffset), .charLen(charLen),
    .parityEn(parityEn), .twoStop(twoStop), .txValid(txValid),
    .rxBit(rxBit), .txReady(txReady), .strobe(strobe)
  );

  serialDatapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .charLen(charLen),
    .parityEn(parityEn), .paritySel(paritySel), .txData(txData),
    .strobe(strobe), .txLine(txLine), .rxBit(rxBit), .rxData(rxData),
    .rxValid(rxValid), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr)
  );
endmodule

// File: rtl/serialEngineChk.sv
module serialEngineChk (
  input logic       clk,
  input logic       rstN,
  input logic       uartEn,
  input logic       txEn,
  input logic       rxEn,
  input logic [1:0] charLen,
  input logic       parityEn,
  input logic       txValid,
  input logic       txReady,
  input logic       txLine,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       rxParityErr
);
  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (!txLine && !txReady));

  // R3
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && charLen != 2'd3) |-> ((rxData >> (3'd5 + 3'(charLen))) == 8'd0));

  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7
  par_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !parityEn) |-> !rxParityErr);

  // R11
  tx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(uartEn && txEn) |-> (!txReady && txLine));

  // R11
  rx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(uartEn && rxEn) |=> !rxValid);
endmodule

bind serialEngine serialEngineChk chk (.*);

// File: tb/serialEngine_test.sv
module serialEngine_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uartEn = 1'b1, txEn = 1'b1, rxEn = 1'b1;
  logic [CNT_W-1:0] bitCount = 24'd16, sampleOffset = 24'd8;
  logic [1:0] charLen = 2'd3;
  logic parityEn = 1'b0, paritySel = 1'b0, twoStop = 1'b0;
  logic [7:0] txData = 8'h00;
  logic txValid = 1'b0;
  logic txReady, txLine, rxLine, rxValid, rxParityErr, rxFrameErr;
  logic [7:0] rxData;
  logic loopback = 1'b1;
  logic rxDrv = 1'b1;

  int vectors = 0;
  int miscompares = 0;
  int rxSeen = 0;
  logic [7:0] gotData = 8'h00;
  logic gotPe = 1'b0, gotFe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rxLine = loopback ? txLine : rxDrv;

  serialEngine uut (
    .clk(clk), .rstN(rstN), .uartEn(uartEn), .txEn(txEn), .rxEn(rxEn),
    .bitCount(bitCount), .sampleOffset(sampleOffset), .charLen(charLen),
    .parityEn(parityEn), .paritySel(paritySel), .twoStop(twoStop),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txLine(txLine),
    .rxLine(rxLine), .rxData(rxData), .rxValid(rxValid),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr)
  );

  always @(negedge clk) begin
    if (rstN && rxValid) begin
      rxSeen  <= rxSeen + 1;
      gotData <= rxData;
      gotPe   <= rxParityErr;
      gotFe   <= rxFrameErr;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maskOf(input logic [1:0] cl);
    return 8'hFF >> (3 - int'(cl));
  endfunction

  function automatic logic parOf(input logic [7:0] d, input logic [1:0] cl,
                                 input logic ps);
    logic [7:0] m;
    m = d & maskOf(cl);
    return ps ? ^m : ~^m;
  endfunction

  task automatic buildFrame(input logic [7:0] d, output logic [11:0] bits,
                            output int n);
    bits = '1;
    bits[0] = 1'b0;
    n = 1;
    for (int i = 0; i < 5 + int'(charLen); i++) begin
      bits[n] = d[i];
      n++;
    end
    if (parityEn) begin
      bits[n] = parOf(d, charLen, paritySel);
      n++;
    end
    bits[n] = 1'b1;
    n++;
    if (twoStop) begin
      bits[n] = 1'b1;
      n++;
    end
  endtask

  // send through the transmitter, check each bit mid-period, and in loopback the decode
  task automatic txFrame(input logic [7:0] d);
    logic [11:0] bits;
    int n, bc, base, nData;
    bc = int'(bitCount);
    nData = 5 + int'(charLen);
    buildFrame(d, bits, n);
    base = rxSeen;
    @(negedge clk);
    check(txReady == 1'b1, "R5 ready before frame", 32'(txReady), 32'd1);
    txData = d;
    txValid = 1'b1;
    @(posedge clk);
    #1 txValid = 1'b0;
    for (int t = 1; t <= n * bc; t++) begin
      @(negedge clk);
      if ((t - 1) % bc == bc / 2) begin
        int idx;
        idx = (t - 1) / bc;
        if (idx == 0)
          check(txLine == bits[idx], "R2 start bit", 32'(txLine), 32'(bits[idx]));
        else if (idx <= nData)
          check(txLine == bits[idx], "R2 R3 data bit", 32'(txLine), 32'(bits[idx]));
        else if (parityEn && idx == nData + 1)
          check(txLine == bits[idx], "R4 parity bit", 32'(txLine), 32'(bits[idx]));
        else
          check(txLine == bits[idx], "R5 stop bit", 32'(txLine), 32'(bits[idx]));
      end
      if (t == n * bc)
        check(txReady == 1'b0, "R5 busy through last stop", 32'(txReady), 32'd0);
    end
    @(negedge clk);
    check(txReady == 1'b1, "R5 ready after frame", 32'(txReady), 32'd1);
    if (loopback) begin
      check(rxSeen == base + 1, "R6 one rx pulse", 32'(rxSeen - base), 32'd1);
      check(gotData == (d & maskOf(charLen)), "R6 R3 rx byte", 32'(gotData),
            32'(d & maskOf(charLen)));
      check(gotPe == 1'b0, "R7 no parity error", 32'(gotPe), 32'd0);
      check(gotFe == 1'b0, "R8 no framing error", 32'(gotFe), 32'd0);
    end
  endtask

  // drive a frame onto rxLine directly; parity bit and stop level given
  task automatic rxSend(input logic [7:0] d, input logic parBit, input logic stopBit);
    int bc;
    bc = int'(bitCount);
    loopback = 1'b0;
    for (int c = 0; c < bc; c++) begin @(negedge clk); rxDrv = 1'b0; end
    for (int i = 0; i < 5 + int'(charLen); i++)
      for (int c = 0; c < bc; c++) begin @(negedge clk); rxDrv = d[i]; end
    if (parityEn)
      for (int c = 0; c < bc; c++) begin @(negedge clk); rxDrv = parBit; end
    for (int c = 0; c < bc; c++) begin @(negedge clk); rxDrv = stopBit; end
    @(negedge clk);
    rxDrv = 1'b1;
    repeat (3 * bc) @(negedge clk);
  endtask

  task automatic rxGlitch(input int len);
    loopback = 1'b0;
    for (int c = 0; c < len; c++) begin @(negedge clk); rxDrv = 1'b0; end
    @(negedge clk);
    rxDrv = 1'b1;
    repeat (3 * int'(bitCount)) @(negedge clk);
  endtask

  task automatic runAll();
    logic [7:0] pats [6];
    int base;
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'h81};

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1 reset line", 32'(txLine), 32'd1);
    check(txReady == 1'b1, "R1 reset ready", 32'(txReady), 32'd1);
    check(rxValid == 1'b0, "R1 reset rxValid", 32'(rxValid), 32'd0);

    // loopback sweep over every format
    for (int cl = 0; cl < 4; cl++)
      for (int pe = 0; pe < 2; pe++)
        for (int ps = 0; ps < 2; ps++)
          for (int ts = 0; ts < 2; ts++)
            for (int p = 0; p < 6; p++) begin
              charLen = 2'(cl); parityEn = 1'(pe); paritySel = 1'(ps); twoStop = 1'(ts);
              txFrame(pats[p]);
            end

    // other bit lengths and sample points
    charLen = 2'd3; parityEn = 1'b1; paritySel = 1'b0; twoStop = 1'b1;
    bitCount = 24'd11; sampleOffset = 24'd8;
    txFrame(8'hC3);
    bitCount = 24'd12; sampleOffset = 24'd2;
    txFrame(8'h96);  // R9 offset below floor still decodes
    bitCount = 24'd40; sampleOffset = 24'd20;
    txFrame(8'h1E);

    // receive errors, driven directly
    bitCount = 24'd16; sampleOffset = 24'd8;
    twoStop = 1'b0; parityEn = 1'b1; paritySel = 1'b1; charLen = 2'd3;
    base = rxSeen;
    rxSend(8'h5A, 1'b1, 1'b1);
    check(rxSeen == base + 1, "R7 frame seen", 32'(rxSeen - base), 32'd1);
    check(gotPe == 1'b1, "R7 even parity mismatch", 32'(gotPe), 32'd1);
    check(gotData == 8'h5A, "R6 data with bad parity", 32'(gotData), 32'h5A);
    rxSend(8'h5A, 1'b0, 1'b1);
    check(gotPe == 1'b0, "R7 even parity good", 32'(gotPe), 32'd0);
    paritySel = 1'b0;
    rxSend(8'h07, 1'b0, 1'b1);
    check(gotPe == 1'b0, "R7 odd parity good", 32'(gotPe), 32'd0);
    rxSend(8'h07, 1'b1, 1'b1);
    check(gotPe == 1'b1, "R7 odd parity mismatch", 32'(gotPe), 32'd1);

    parityEn = 1'b0;
    base = rxSeen;
    rxSend(8'h33, 1'b0, 1'b0);
    check(rxSeen == base + 1, "R8 single pulse on bad stop", 32'(rxSeen - base), 32'd1);
    check(gotFe == 1'b1, "R8 framing error", 32'(gotFe), 32'd1);
    rxSend(8'h33, 1'b0, 1'b1);
    check(gotFe == 1'b0, "R8 framing clear", 32'(gotFe), 32'd0);

    charLen = 2'd0;
    rxSend(8'hFF, 1'b0, 1'b1);
    check(gotData == 8'h1F, "R3 five-bit zero extend", 32'(gotData), 32'h1F);
    charLen = 2'd2;
    rxSend(8'hFF, 1'b0, 1'b1);
    check(gotData == 8'h7F, "R3 seven-bit zero extend", 32'(gotData), 32'h7F);
    charLen = 2'd3;

    // glitch rejection and the sample floor
    base = rxSeen;
    rxGlitch(8);
    check(rxSeen == base, "R10 glitch rejected", 32'(rxSeen - base), 32'd0);
    sampleOffset = 24'd2;
    rxGlitch(6);
    check(rxSeen == base, "R9 floor rejects short low", 32'(rxSeen - base), 32'd0);
    rxSend(8'hB4, 1'b0, 1'b1);
    check(gotData == 8'hB4, "R9 decode at floor", 32'(gotData), 32'hB4);
    sampleOffset = 24'd8;

    // enables
    txEn = 1'b0;
    @(negedge clk);
    txValid = 1'b1; txData = 8'h00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(txReady == 1'b0, "R11 tx disabled ready", 32'(txReady), 32'd0);
      check(txLine == 1'b1, "R11 tx disabled line", 32'(txLine), 32'd1);
    end
    txValid = 1'b0;
    txEn = 1'b1; uartEn = 1'b0;
    @(negedge clk);
    check(txReady == 1'b0, "R11 uart disabled ready", 32'(txReady), 32'd0);
    base = rxSeen;
    rxSend(8'h42, 1'b0, 1'b1);
    check(rxSeen == base, "R11 uart disabled rx", 32'(rxSeen - base), 32'd0);
    uartEn = 1'b1; rxEn = 1'b0;
    rxSend(8'h42, 1'b0, 1'b1);
    check(rxSeen == base, "R11 rx disabled", 32'(rxSeen - base), 32'd0);
    rxEn = 1'b1;
    rxSend(8'h42, 1'b0, 1'b1);
    check(rxSeen == base + 1 && gotData == 8'h42, "R11 rx re-enabled",
          32'(gotData), 32'h42);
    loopback = 1'b1;
    txFrame(8'h6D);
  endtask

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    fork
      runAll();
      begin
        repeat (200000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule